// File: doc/BRIEF.md
# Two-Channel PIO Access Sequencer

This block runs the channel-access transaction of a single-wire serial slave that owns two open-drain output channels, A and B. The link layer passes in whole received bytes and slot-level events. When the command code arrives with the block idle, the block takes in two control bytes and presents one info byte. Every following time slot then goes to channel A, to channel B, or to both. Which one depends on the channel-select code and the interleave bit carried in the first control byte.

The link layer marks four points in each slot. `slot_start` marks the start of the slot, and `slot_read` gives its direction. `slot_mid` marks the instant the master's bit is sampled, and `slot_wbit` carries that bit. `line_idle` marks the return of the line to idle. Reads sample the pins at slot start. A written 1 reaches a channel flip-flop at the sampling instant. A written 0 reaches it at the return to idle. A bus reset from the link ends the transaction and leaves the flip-flops unchanged. Two activity latches record any pin change and are cleared on request by the control byte.

The controller has these states. ST_IDLE waits for a command. ST_CTRL1 and ST_CTRL2 take the control bytes. ST_INFO presents the info byte for one cycle. ST_ACCESS steers slots. ST_HALT ignores everything. These are the transitions. T_CMD goes from IDLE to CTRL1 on the command code. T_FOREIGN goes from IDLE to HALT on any other byte. T_SEL goes from CTRL1 to CTRL2 on a legal select. T_BADSEL goes from CTRL1 to HALT on select 00. T_CTRL2 goes from CTRL2 to INFO. T_SEND goes from INFO to ACCESS. T_BUSRST goes from any state to IDLE and has priority over every other transition.

Top module: `pio_access_seq`

## Requirements
- R1: After `rst_n` is released, both channel flip-flops are 0, `tx_info_valid` is 0 and `access_on` is 0.
- R2: In ST_IDLE, a received byte equal to F5h starts the transaction. Any other byte sends the block to ST_HALT, where all bytes and slots are ignored until `bus_reset`.
- R3: Control byte 1 carries the select code in bits [1:0], the interleave bit in bit 2 and the activity-clear request in bit 7. The content of control byte 2 has no effect. In the cycle after control byte 2 is accepted, `tx_info_valid` is 1 for exactly one cycle. `access_on` goes to 1 in the following cycle.
- R4: Select code 00 sends the block to ST_HALT, and no info byte is presented. Until `bus_reset`, slots change neither the flip-flops nor `tx_bit`.
- R5: With one channel selected (select 01 = A, 10 = B), a read slot samples that pin at `slot_start`, and `tx_bit` shows the sample from the next cycle on. Pin changes later in the slot do not alter `tx_bit`.
- R6: A written 1 updates the target flip-flop on the cycle after `slot_mid`, never at `slot_start`.
- R7: A written 0 leaves the flip-flop unchanged at `slot_mid` and updates it on the cycle after `line_idle`.
- R8: With select 11 and interleave 0, successive slots (read or write) alternate A, B, A, and so on, beginning with A after every entry into ST_ACCESS.
- R9: With select 11 and interleave 1, both pins are sampled at the start of the A slot and A's level is returned there. The following slot returns the held B level, whatever pin B does in between.
- R10: With select 11 and interleave 1, the bit written in the A slot is held. Both flip-flops update together at the update instant of the following B slot, which is set by B's bit as in R6 or R7.
- R11: `bus_reset` returns the block to ST_IDLE with `access_on` 0. The flip-flops keep their values, and slots are ignored.
- R12: The info byte is {2'b00, act_b, act_a, pin_b, pin_a, ff_b, ff_a}, captured when control byte 2 is accepted. An activity latch sets on any change of its pin. It is cleared when a legal control byte 1 requests it. A pin change in the same cycle as the clear leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse from the link layer |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| slot_start | input | 1 | Pulse at the start of a time slot |
| slot_read | input | 1 | Slot is a read slot, valid with `slot_start` |
| slot_mid | input | 1 | Pulse at the master bit sampling instant |
| slot_wbit | input | 1 | Written bit, valid with `slot_mid` |
| line_idle | input | 1 | Pulse when the line returns to idle |
| pin_a | input | 1 | Synchronised level of pin A |
| pin_b | input | 1 | Synchronised level of pin B |
| chan_ff_a | output | 1 | Output transistor flip-flop of channel A |
| chan_ff_b | output | 1 | Output transistor flip-flop of channel B |
| tx_bit | output | 1 | Bit to send in the current read slot |
| tx_info | output | 8 | Info byte |
| tx_info_valid | output | 1 | Info byte is presented this cycle |
| access_on | output | 1 | Block is in the slot-steering state |

## Verification
The activity clear requested by control byte 1 and the setting of an activity latch by a pin edge can occur in the same cycle. The bench provokes this by toggling pin A in the very cycle the clearing control byte is accepted. It then reads the result through the info byte, where bit 4 must still be 1. A second transaction with the pins held still must then show both latch bits cleared.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int NCH        = 2;
    localparam int SEL_LSB    = 0;
    localparam int IC_BIT     = 2;
    localparam int CLR_BIT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL1,
        ST_CTRL2,
        ST_INFO,
        ST_ACCESS,
        ST_HALT
    } state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_BOTH = 2'b11
    } sel_t;

endpackage

// File: rtl/pio_ctrl_fsm.sv
module pio_ctrl_fsm
    import pio_seq_pkg::*;
#(
    parameter logic [7:0] CMD_CODE = 8'hF5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output sel_t       sel,
    output logic       ic,
    output logic       act_clr,
    output logic       info_cap,
    output logic       info_valid,
    output logic       access_on
);

    state_t state, nxt;
    sel_t   rx_sel;

    assign rx_sel = sel_t'(rx_byte[SEL_LSB +: 2]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        act_clr    = 1'b0;
        info_cap   = 1'b0;
        info_valid = 1'b0;
        access_on  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rx_valid) nxt = (rx_byte == CMD_CODE) ? ST_CTRL1 : ST_HALT;
            end
            ST_CTRL1: begin
                if (rx_valid) begin
                    if (rx_sel == SEL_NONE) begin
                        nxt = ST_HALT;
                    end else begin
                        nxt     = ST_CTRL2;
                        act_clr = rx_byte[CLR_BIT];
                    end
                end
            end
            ST_CTRL2: begin
                if (rx_valid) begin
                    nxt      = ST_INFO;
                    info_cap = 1'b1;
                end
            end
            ST_INFO: begin
                info_valid = 1'b1;
                nxt        = ST_ACCESS;
            end
            ST_ACCESS: access_on = 1'b1;
            ST_HALT:   nxt = ST_HALT;
        endcase
        if (bus_reset) begin
            nxt      = ST_IDLE;
            act_clr  = 1'b0;
            info_cap = 1'b0;
        end
    end

    // control byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= SEL_NONE;
            ic  <= 1'b0;
        end else if (state == ST_CTRL1 && rx_valid && !bus_reset) begin
            sel <= rx_sel;
            ic  <= rx_byte[IC_BIT];
        end
    end

endmodule

// File: rtl/pio_activity.sv
module pio_activity
    import pio_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pins,
    input  logic           clr,
    output logic [NCH-1:0] act
);

    logic [NCH-1:0] prev_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                act[g]    <= 1'b0;
            end else begin
                prev_q[g] <= pins[g];
                if (pins[g] != prev_q[g]) act[g] <= 1'b1;   // set wins
                else if (clr)             act[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pio_slot_steer.sv
module pio_slot_steer
    import pio_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  sel_t           sel,
    input  logic           ic,
    input  logic           slot_start,
    input  logic           slot_read,
    input  logic           slot_mid,
    input  logic           slot_wbit,
    input  logic           line_idle,
    input  logic [NCH-1:0] pins,
    output logic [NCH-1:0] ff,
    output logic           tx_bit
);

    logic           ph_q, cur_ch_q, cur_rd_q, cur_live_q;
    logic           hold_a_q, hold_b_q;
    logic           pend_v_q;
    logic [NCH-1:0] pend_mask_q, pend_val_q;
    logic           both, sync_md, slot_ch, mid_hit;
    logic [NCH-1:0] wr_mask, wr_val, ff_n;

    assign both    = (sel == SEL_BOTH);
    assign sync_md = both && ic;
    assign slot_ch = (sel == SEL_B) ? 1'b1 : (sel == SEL_A) ? 1'b0 : ph_q;
    assign mid_hit = en && slot_mid && cur_live_q && !cur_rd_q;

    always_comb begin
        wr_mask = '0;
        wr_val  = {NCH{slot_wbit}};
        if (sync_md) begin
            if (cur_ch_q) begin
                wr_mask = '1;
                wr_val  = {slot_wbit, hold_a_q};
            end
        end else begin
            wr_mask = NCH'(1) << cur_ch_q;
        end
    end

    always_comb begin
        ff_n = ff;
        if (en && line_idle && pend_v_q) begin
            for (int i = 0; i < NCH; i++)
                if (pend_mask_q[i]) ff_n[i] = pend_val_q[i];
        end
        if (mid_hit && slot_wbit) begin
            for (int i = 0; i < NCH; i++)
                if (wr_mask[i]) ff_n[i] = wr_val[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff          <= '0;
            tx_bit      <= 1'b0;
            ph_q        <= 1'b0;
            cur_ch_q    <= 1'b0;
            cur_rd_q    <= 1'b0;
            cur_live_q  <= 1'b0;
            hold_a_q    <= 1'b0;
            hold_b_q    <= 1'b0;
            pend_v_q    <= 1'b0;
            pend_mask_q <= '0;
            pend_val_q  <= '0;
        end else begin
            ff <= ff_n;
            if (!en) begin
                ph_q       <= 1'b0;
                cur_live_q <= 1'b0;
                pend_v_q   <= 1'b0;
            end else begin
                if (line_idle && pend_v_q) pend_v_q <= 1'b0;
                if (mid_hit) begin
                    cur_live_q <= 1'b0;
                    if (sync_md && !cur_ch_q) hold_a_q <= slot_wbit;
                    if (!slot_wbit && (wr_mask != '0)) begin
                        pend_v_q    <= 1'b1;
                        pend_mask_q <= wr_mask;
                        pend_val_q  <= wr_val;
                    end
                end
                if (slot_start) begin
                    cur_ch_q   <= slot_ch;
                    cur_rd_q   <= slot_read;
                    cur_live_q <= 1'b1;
                    if (both) ph_q <= ~ph_q;
                    if (slot_read) begin
                        if (sync_md && !slot_ch) begin
                            tx_bit   <= pins[0];
                            hold_b_q <= pins[1];
                        end else if (sync_md) begin
                            tx_bit <= hold_b_q;
                        end else begin
                            tx_bit <= pins[slot_ch];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pio_access_seq.sv
module pio_access_seq
    import pio_seq_pkg::*;
#(
    parameter logic [7:0] CMD_CODE = 8'hF5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       slot_start,
    input  logic       slot_read,
    input  logic       slot_mid,
    input  logic       slot_wbit,
    input  logic       line_idle,
    input  logic       pin_a,
    input  logic       pin_b,
    output logic       chan_ff_a,
    output logic       chan_ff_b,
    output logic       tx_bit,
    output logic [7:0] tx_info,
    output logic       tx_info_valid,
    output logic       access_on
);

    localparam int INFO_PAD = 8 - 3 * NCH;

    sel_t           sel;
    logic           ic, act_clr, info_cap;
    logic [NCH-1:0] pins, ff, act;

    assign pins      = {pin_b, pin_a};
    assign chan_ff_a = ff[0];
    assign chan_ff_b = ff[1];

    pio_ctrl_fsm #(.CMD_CODE(CMD_CODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .sel        (sel),
        .ic         (ic),
        .act_clr    (act_clr),
        .info_cap   (info_cap),
        .info_valid (tx_info_valid),
        .access_on  (access_on)
    );

    pio_slot_steer u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (access_on),
        .sel        (sel),
        .ic         (ic),
        .slot_start (slot_start),
        .slot_read  (slot_read),
        .slot_mid   (slot_mid),
        .slot_wbit  (slot_wbit),
        .line_idle  (line_idle),
        .pins       (pins),
        .ff         (ff),
        .tx_bit     (tx_bit)
    );

    pio_activity u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins),
        .clr   (act_clr),
        .act   (act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tx_info <= '0;
        else if (info_cap) tx_info <= {{INFO_PAD{1'b0}}, act, pins, ff};
    end

endmodule

// File: rtl/pio_access_seq_chk.sv
module pio_access_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic slot_start,
    input logic slot_mid,
    input logic line_idle,
    input logic chan_ff_a,
    input logic chan_ff_b,
    input logic tx_bit,
    input logic tx_info_valid,
    input logic access_on
);

    assert_info_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_info_valid |=> !tx_info_valid);

    assert_access_follows_info_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_info_valid |=> access_on);

    assert_tx_only_on_slot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable(tx_bit));

    assert_ff_only_on_mid_or_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_mid && !line_idle) |=> $stable({chan_ff_b, chan_ff_a}));

    assert_ff_frozen_outside_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !access_on |=> $stable({chan_ff_b, chan_ff_a}));

endmodule

bind pio_access_seq pio_access_seq_chk u_chk (.*);

// File: tb/test_pio_access_seq.sv
module test_pio_access_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       slot_start = 1'b0, slot_read = 1'b0, slot_mid = 1'b0, slot_wbit = 1'b0, line_idle = 1'b0;
    logic       pin_a = 1'b0, pin_b = 1'b0;
    logic       chan_ff_a, chan_ff_b, tx_bit, tx_info_valid, access_on;
    logic [7:0] tx_info;
    int         n_checks = 0, n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pio_access_seq i_pio_access_seq (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ffs();
        return {6'b0, chan_ff_b, chan_ff_a};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic open_access(input logic [7:0] c1, input logic [7:0] c2);
        pulse_bus_reset();
        send_byte(8'hF5);
        send_byte(c1);
        send_byte(c2);
        check("R3 info valid", {7'b0, tx_info_valid}, 8'h01);
        @(negedge clk);
        check("R3 info pulse ends", {7'b0, tx_info_valid}, 8'h00);
        check("R3 access on", {7'b0, access_on}, 8'h01);
    endtask

    task automatic rd_slot(output logic v);
        @(negedge clk); slot_start = 1'b1; slot_read = 1'b1;
        @(negedge clk); slot_start = 1'b0; v = tx_bit; slot_mid = 1'b1;
        @(negedge clk); slot_mid = 1'b0; line_idle = 1'b1;
        @(negedge clk); line_idle = 1'b0;
    endtask

    task automatic wr_slot(input logic b, output logic [7:0] at_start, output logic [7:0] at_mid,
                           output logic [7:0] at_idle);
        @(negedge clk); slot_start = 1'b1; slot_read = 1'b0;
        @(negedge clk); slot_start = 1'b0; at_start = ffs(); slot_mid = 1'b1; slot_wbit = b;
        @(negedge clk); slot_mid = 1'b0; at_mid = ffs(); line_idle = 1'b1;
        @(negedge clk); line_idle = 1'b0; at_idle = ffs();
    endtask

    task automatic t_reset();
        check("R1 ff after reset", ffs(), 8'h00);
        check("R1 info valid after reset", {7'b0, tx_info_valid}, 8'h00);
        check("R1 access after reset", {7'b0, access_on}, 8'h00);
    endtask

    task automatic t_foreign();
        pulse_bus_reset();
        send_byte(8'h33);
        send_byte(8'hF5);
        send_byte(8'h01);
        send_byte(8'h00);
        check("R2 no info after foreign command", {7'b0, tx_info_valid}, 8'h00);
        @(negedge clk);
        check("R2 no access after foreign command", {7'b0, access_on}, 8'h00);
    endtask

    task automatic t_activity();
        pulse_bus_reset();
        send_byte(8'hF5);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h81; pin_a = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        send_byte(8'h00);
        check("R12 info with edge during clear", tx_info, 8'h14);
        open_access(8'h81, 8'hFF);
        check("R12 info after clear, pins still", tx_info, 8'h04);
    endtask

    task automatic t_single_a();
        logic v;
        logic [7:0] s, m, i;
        open_access(8'h01, 8'h5A);
        rd_slot(v);
        check("R5 read A high", {7'b0, v}, 8'h01);
        @(negedge clk); slot_start = 1'b1; slot_read = 1'b1;
        @(negedge clk); slot_start = 1'b0; pin_a = 1'b0;
        @(negedge clk);
        check("R5 late pin change ignored", {7'b0, tx_bit}, 8'h01);
        slot_mid = 1'b1;
        @(negedge clk); slot_mid = 1'b0; line_idle = 1'b1;
        @(negedge clk); line_idle = 1'b0;
        rd_slot(v);
        check("R5 read A low", {7'b0, v}, 8'h00);
        wr_slot(1'b1, s, m, i);
        check("R6 no change at slot start", s, 8'h00);
        check("R6 write 1 at mid", m, 8'h01);
        wr_slot(1'b0, s, m, i);
        check("R7 write 0 not at mid", m, 8'h01);
        check("R7 write 0 at idle", i, 8'h00);
    endtask

    task automatic t_single_b();
        logic v;
        logic [7:0] s, m, i;
        open_access(8'h02, 8'h00);
        pin_b = 1'b1;
        rd_slot(v);
        check("R5 read B", {7'b0, v}, 8'h01);
        wr_slot(1'b1, s, m, i);
        check("R6 write 1 to B", m, 8'h02);
    endtask

    task automatic t_async();
        logic v;
        logic [7:0] s, m, i;
        open_access(8'h03, 8'h00);
        pin_a = 1'b1; pin_b = 1'b0;
        rd_slot(v); check("R8 slot 1 is A", {7'b0, v}, 8'h01);
        rd_slot(v); check("R8 slot 2 is B", {7'b0, v}, 8'h00);
        rd_slot(v); check("R8 slot 3 is A", {7'b0, v}, 8'h01);
        open_access(8'h03, 8'h00);
        wr_slot(1'b1, s, m, i); check("R8 write slot 1 to A", i, 8'h03);
        wr_slot(1'b0, s, m, i); check("R8 write slot 2 to B", i, 8'h01);
        wr_slot(1'b0, s, m, i); check("R8 write slot 3 to A", i, 8'h00);
    endtask

    task automatic t_sync_read();
        logic v;
        open_access(8'h07, 8'h00);
        pin_a = 1'b1; pin_b = 1'b1;
        rd_slot(v); check("R9 A slot returns A", {7'b0, v}, 8'h01);
        pin_b = 1'b0;
        rd_slot(v); check("R9 B slot returns held B", {7'b0, v}, 8'h01);
        pin_a = 1'b0;
        rd_slot(v); check("R9 next A slot resamples", {7'b0, v}, 8'h00);
    endtask

    task automatic t_sync_write();
        logic [7:0] s, m, i;
        open_access(8'h07, 8'h00);
        wr_slot(1'b1, s, m, i);
        check("R10 A bit held at mid", m, 8'h00);
        check("R10 A bit held at idle", i, 8'h00);
        wr_slot(1'b0, s, m, i);
        check("R10 no update at B mid", m, 8'h00);
        check("R10 both update at B idle", i, 8'h01);
    endtask

    task automatic t_badsel();
        logic v;
        logic t0;
        logic [7:0] s, m, i;
        pulse_bus_reset();
        send_byte(8'hF5);
        send_byte(8'h80);
        send_byte(8'h00);
        check("R4 no info on select 00", {7'b0, tx_info_valid}, 8'h00);
        wr_slot(1'b0, s, m, i);
        check("R4 write ignored", i, 8'h01);
        t0 = tx_bit;
        pin_a = ~t0; pin_b = ~t0;
        rd_slot(v);
        check("R4 tx_bit unchanged", {7'b0, v}, {7'b0, t0});
        check("R4 access off", {7'b0, access_on}, 8'h00);
    endtask

    task automatic t_bus_reset();
        logic [7:0] s, m, i;
        open_access(8'h01, 8'h00);
        pulse_bus_reset();
        check("R11 access off after bus reset", {7'b0, access_on}, 8'h00);
        check("R11 ff kept", ffs(), 8'h01);
        wr_slot(1'b0, s, m, i);
        check("R11 slot ignored", i, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_foreign();
        t_activity();
        t_single_a();
        t_single_b();
        t_async();
        t_sync_read();
        t_sync_write();
        t_badsel();
        t_bus_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule